// File: doc/BRIEF.md
# Serial EEPROM Word Reader

This block fetches a run of 16-bit words from a three-wire serial EEPROM (chip select, serial clock, data-in to the memory, data-out from the memory) and hands them to a consumer as a byte stream. A requester raises `startReq` for one cycle with an even byte address and an even, nonzero byte count. The block halves the address to get the first word address. It then runs one complete, separately framed read transaction per word, raising the word address by one after each word.

Each transaction has a fixed sequence. Chip select is held low for one phase and then raised. One clock pulse is given with data-in at zero. The three-bit read opcode and the six-bit word address follow, most significant bit first. Sixteen data bits are then clocked in, also most significant bit first. Every pin level lasts a whole number of phases, and each phase is `PHASE_CLKS` system clocks long, so the slowest legal memory timing can be met by choosing that parameter. The captured word leaves on a valid/ready byte port, low byte first. While the consumer stalls, the serial engine waits with chip select low. A malformed request is rejected with a one-cycle error pulse and causes no bus activity.

Top module: `eeprom_word_reader`

## Requirements
- R1: A start request with an odd byte address, an odd byte count or a zero byte count produces a one-cycle `errFlag` pulse in the cycle after the request. `busy` stays low and `romCs` never rises.
- R2: Every word begins with one phase of `romCs` low. `romCs` then rises while `romSk` and `romDi` are both low, and exactly one `romSk` pulse with `romDi` = 0 comes before the first opcode bit. `romSk` only pulses while `romCs` is high, and each word has exactly 26 clock pulses.
- R3: The opcode bits 1, 1, 0 are sent in that order, then the word address, most significant bit first. Each bit is held on `romDi` through a low, high, low sequence of `romSk`, and `romDi` never changes in a cycle where `romSk` changes.
- R4: The 16 data bits are taken from `romDo` while `romSk` is high, one per clock pulse, and the first bit becomes bit 15 of the word.
- R5: The first word address is the byte address divided by two. It increments by one per word and wraps modulo 64, and the number of bytes delivered equals the requested count.
- R6: `romCs` falls after each word and is low in every cycle where `outValid` is high.
- R7: Each word is delivered as two bytes, bits 7:0 first and bits 15:8 second.
- R8: While `outValid` is high and `outReady` is low, `outValid` stays high, `outByte` stays unchanged and no serial activity takes place.
- R9: Every level of `romSk` lasts at least `PHASE_CLKS` system clocks.
- R10: `busy` is high from the accepted start until the transfer ends. `done` pulses for exactly one cycle after the final byte is accepted. A start request while `busy` is high is ignored.
- R11: A valid start request presented in the cycle where `done` is high is accepted, and `busy` is high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | One-cycle request to start a transfer |
| startAddr | input | 7 | Byte address, must be even |
| startCount | input | 8 | Byte count, must be even and nonzero |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at end of transfer |
| errFlag | output | 1 | One-cycle pulse for a rejected request |
| outValid | output | 1 | Byte available on outByte |
| outReady | input | 1 | Consumer accepts the byte |
| outByte | output | 8 | Output byte |
| romCs | output | 1 | Memory chip select, active high |
| romSk | output | 1 | Memory serial clock |
| romDi | output | 1 | Serial data to the memory |
| romDo | input | 1 | Serial data from the memory |

## Verification
The end-of-transfer pulse on `done` and the acceptance of a new request can fall in the same cycle, because the controller is already idle while `done` is high. The bench waits until it sees `done`, raises `startReq` with a different address in that same cycle, and judges the outcome by `busy` one cycle later and by the byte values of both transfers. A second overlap, a start request arriving in the middle of a transfer, is judged by checking that the byte stream still matches only the first request.

// File: rtl/eeprom_rd_pkg.sv
package eeprom_rd_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CSLO,
    ST_CSHI,
    ST_DUMHI,
    ST_DUMLO,
    ST_TX,
    ST_RX,
    ST_CSEND,
    ST_OUTLO,
    ST_OUTHI
  } rdState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // capture start address and count
    logic runTimer;  // phase timer counts
    logic txLoad;    // reload opcode/address shifter
    logic txShift;   // advance opcode/address shifter
    logic rxSample;  // capture romDo into the word shifter
    logic wordStep;  // next word address, one fewer word left
    logic pinCs;
    logic pinSk;
    logic diSel;     // drive romDi from the shifter
    logic hiSel;     // present upper byte
  } rdStrobe_t;

endpackage

// File: rtl/eeprom_rd_datapath.sv
module eeprom_rd_datapath
  import eeprom_rd_pkg::*;
#(
  parameter int ADDR_BITS  = 6,
  parameter int DATA_BITS  = 16,
  parameter int CNT_W      = 8,
  parameter int PHASE_CLKS = 4,
  parameter int CMD_BITS   = 3,
  parameter logic [CMD_BITS-1:0] READ_CMD = 3'b110
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  rdStrobe_t              strobe,
  input  logic [ADDR_BITS-1:0]   firstWord,
  input  logic [CNT_W-2:0]       wordCount,
  input  logic                   romDo,
  output logic                   phaseEnd,
  output logic                   lastWord,
  output logic [DATA_BITS/2-1:0] outByte,
  output logic                   romCs,
  output logic                   romSk,
  output logic                   romDi
);

  localparam int TX_BITS = CMD_BITS + ADDR_BITS;
  localparam int BYTE_W  = DATA_BITS / 2;
  localparam int PH_W    = (PHASE_CLKS > 2) ? $clog2(PHASE_CLKS) : 1;
  localparam int AGE_W   = $clog2(PHASE_CLKS + 1);

  logic [PH_W-1:0]      phCnt;
  logic [ADDR_BITS-1:0] wordAddr;
  logic [CNT_W-2:0]     wordsLeft;
  logic [TX_BITS-1:0]   txReg;
  logic [DATA_BITS-1:0] rxReg;

  assign phaseEnd = strobe.runTimer && (phCnt == PH_W'(PHASE_CLKS - 1));
  assign lastWord = (wordsLeft == (CNT_W-1)'(1));
  assign outByte  = strobe.hiSel ? rxReg[DATA_BITS-1:BYTE_W] : rxReg[BYTE_W-1:0];

  // phase timer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phCnt <= '0;
    end else if (!strobe.runTimer || phaseEnd) begin
      phCnt <= '0;
    end else begin
      phCnt <= phCnt + 1'b1;
    end
  end

  // word address and remaining words
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wordAddr  <= '0;
      wordsLeft <= '0;
    end else if (strobe.load) begin
      wordAddr  <= firstWord;
      wordsLeft <= wordCount;
    end else if (strobe.wordStep) begin
      wordAddr  <= wordAddr + 1'b1;
      wordsLeft <= wordsLeft - 1'b1;
    end
  end

  // opcode and address shifter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txReg <= '0;
    end else if (strobe.txLoad) begin
      txReg <= {READ_CMD, wordAddr};
    end else if (strobe.txShift) begin
      txReg <= {txReg[TX_BITS-2:0], 1'b0};
    end
  end

  // incoming word shifter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxReg <= '0;
    end else if (strobe.rxSample) begin
      rxReg <= {rxReg[DATA_BITS-2:0], romDo};
    end
  end

  // registered pins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      romCs <= 1'b0;
      romSk <= 1'b0;
      romDi <= 1'b0;
    end else begin
      romCs <= strobe.pinCs;
      romSk <= strobe.pinSk;
      romDi <= strobe.diSel ? txReg[TX_BITS-1] : 1'b0;
    end
  end

  // level-age tracker for the serial clock
  logic             skPrev;
  logic [AGE_W-1:0] skAge;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      skPrev <= 1'b0;
      skAge  <= AGE_W'(PHASE_CLKS);
    end else begin
      skPrev <= romSk;
      if (romSk != skPrev) begin
        skAge <= AGE_W'(1);
      end else if (skAge < AGE_W'(PHASE_CLKS)) begin
        skAge <= skAge + 1'b1;
      end
    end
  end

  // R9
  sk_phase_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (romSk != skPrev) |-> (skAge >= AGE_W'(PHASE_CLKS)));

  // R2
  cs_rise_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(romCs) |-> (!romSk && !romDi));

  // R2
  sk_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(romSk) |-> romCs);

  // R3
  di_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(romSk) || $fell(romSk)) |-> $stable(romDi));

endmodule

// File: rtl/eeprom_rd_ctrl.sv
module eeprom_rd_ctrl
  import eeprom_rd_pkg::*;
#(
  parameter int TX_BITS   = 9,
  parameter int DATA_BITS = 16,
  parameter int CNT_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             startReq,
  input  logic             addrLsb,
  input  logic [CNT_W-1:0] startCount,
  input  logic             phaseEnd,
  input  logic             lastWord,
  input  logic             outReady,
  output rdStrobe_t        strobe,
  output logic             busy,
  output logic             done,
  output logic             errFlag,
  output logic             outValid
);

  localparam int MAXB  = (TX_BITS > DATA_BITS) ? TX_BITS : DATA_BITS;
  localparam int IDX_W = $clog2(MAXB);

  rdState_t         state;
  logic [IDX_W-1:0] bitIdx;
  logic [1:0]       subPh;
  logic             badReq;
  logic             txLast;
  logic             rxLast;

  assign badReq   = addrLsb || startCount[0] || (startCount == '0);
  assign txLast   = (bitIdx == IDX_W'(TX_BITS - 1));
  assign rxLast   = (bitIdx == IDX_W'(DATA_BITS - 1));
  assign busy     = (state != ST_IDLE);
  assign outValid = (state == ST_OUTLO) || (state == ST_OUTHI);

  always_comb begin
    strobe = '0;
    unique case (state)
      ST_IDLE:  strobe.load = startReq && !badReq;
      ST_CSLO: begin
        strobe.runTimer = 1'b1;
        strobe.txLoad   = 1'b1;
      end
      ST_CSHI: begin
        strobe.runTimer = 1'b1;
        strobe.pinCs    = 1'b1;
      end
      ST_DUMHI: begin
        strobe.runTimer = 1'b1;
        strobe.pinCs    = 1'b1;
        strobe.pinSk    = 1'b1;
      end
      ST_DUMLO: begin
        strobe.runTimer = 1'b1;
        strobe.pinCs    = 1'b1;
      end
      ST_TX: begin
        strobe.runTimer = 1'b1;
        strobe.pinCs    = 1'b1;
        strobe.pinSk    = (subPh == 2'd1);
        strobe.diSel    = 1'b1;
        strobe.txShift  = phaseEnd && (subPh == 2'd2) && !txLast;
      end
      ST_RX: begin
        strobe.runTimer = 1'b1;
        strobe.pinCs    = 1'b1;
        strobe.pinSk    = (subPh == 2'd0);
        strobe.diSel    = 1'b1;
        strobe.rxSample = phaseEnd && (subPh == 2'd0);
      end
      ST_CSEND: strobe.runTimer = 1'b1;
      ST_OUTLO: strobe.hiSel = 1'b0;
      ST_OUTHI: begin
        strobe.hiSel    = 1'b1;
        strobe.wordStep = outReady;
      end
      default: strobe = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bitIdx  <= '0;
      subPh   <= '0;
      done    <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      done    <= (state == ST_OUTHI) && outReady && lastWord;
      errFlag <= (state == ST_IDLE) && startReq && badReq;
      unique case (state)
        ST_IDLE:  if (startReq && !badReq) state <= ST_CSLO;
        ST_CSLO:  if (phaseEnd) state <= ST_CSHI;
        ST_CSHI:  if (phaseEnd) state <= ST_DUMHI;
        ST_DUMHI: if (phaseEnd) state <= ST_DUMLO;
        ST_DUMLO: begin
          if (phaseEnd) begin
            state  <= ST_TX;
            bitIdx <= '0;
            subPh  <= 2'd0;
          end
        end
        ST_TX: begin
          if (phaseEnd) begin
            if (subPh == 2'd2) begin
              subPh  <= 2'd0;
              bitIdx <= txLast ? '0 : bitIdx + 1'b1;
              if (txLast) state <= ST_RX;
            end else begin
              subPh <= subPh + 1'b1;
            end
          end
        end
        ST_RX: begin
          if (phaseEnd) begin
            if (subPh == 2'd0) begin
              subPh <= 2'd1;
            end else begin
              subPh  <= 2'd0;
              bitIdx <= rxLast ? '0 : bitIdx + 1'b1;
              if (rxLast) state <= ST_CSEND;
            end
          end
        end
        ST_CSEND: if (phaseEnd) state <= ST_OUTLO;
        ST_OUTLO: if (outReady) state <= ST_OUTHI;
        ST_OUTHI: if (outReady) state <= lastWord ? ST_IDLE : ST_CSLO;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R1
  err_no_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    errFlag |-> !busy);

  // R10
  busy_ignores_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && startReq && !(outValid && outReady)) |=> busy);

endmodule

// File: rtl/eeprom_word_reader.sv
module eeprom_word_reader
  import eeprom_rd_pkg::*;
#(
  parameter int ADDR_BITS  = 6,
  parameter int DATA_BITS  = 16,
  parameter int CNT_W      = 8,
  parameter int PHASE_CLKS = 4,
  parameter int CMD_BITS   = 3,
  parameter logic [CMD_BITS-1:0] READ_CMD = 3'b110
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   startReq,
  input  logic [ADDR_BITS:0]     startAddr,
  input  logic [CNT_W-1:0]       startCount,
  output logic                   busy,
  output logic                   done,
  output logic                   errFlag,
  output logic                   outValid,
  input  logic                   outReady,
  output logic [DATA_BITS/2-1:0] outByte,
  output logic                   romCs,
  output logic                   romSk,
  output logic                   romDi,
  input  logic                   romDo
);

  localparam int TX_BITS = CMD_BITS + ADDR_BITS;

  rdStrobe_t strobe;
  logic      phaseEnd;
  logic      lastWord;

  eeprom_rd_ctrl #(
    .TX_BITS  (TX_BITS),
    .DATA_BITS(DATA_BITS),
    .CNT_W    (CNT_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .startReq  (startReq),
    .addrLsb   (startAddr[0]),
    .startCount(startCount),
    .phaseEnd  (phaseEnd),
    .lastWord  (lastWord),
    .outReady  (outReady),
    .strobe    (strobe),
    .busy      (busy),
    .done      (done),
    .errFlag   (errFlag),
    .outValid  (outValid)
  );

  eeprom_rd_datapath #(
    .ADDR_BITS (ADDR_BITS),
    .DATA_BITS (DATA_BITS),
    .CNT_W     (CNT_W),
    .PHASE_CLKS(PHASE_CLKS),
    .CMD_BITS  (CMD_BITS),
    .READ_CMD  (READ_CMD)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .firstWord(startAddr[ADDR_BITS:1]),
    .wordCount(startCount[CNT_W-1:1]),
    .romDo    (romDo),
    .phaseEnd (phaseEnd),
    .lastWord (lastWord),
    .outByte  (outByte),
    .romCs    (romCs),
    .romSk    (romSk),
    .romDi    (romDi)
  );

  // R6
  cs_low_on_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> !romCs);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |=> (outValid && $stable(outByte)));

endmodule

// File: tb/eeprom_word_reader_bench.sv
module eeprom_word_reader_bench;

  localparam int PH = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       startReq = 1'b0;
  logic [6:0] startAddr = '0;
  logic [7:0] startCount = '0;
  logic       outReady = 1'b1;
  logic       romDo = 1'b0;
  logic       busy, done, errFlag, outValid, romCs, romSk, romDi;
  logic [7:0] outByte;

  always #2.5 clk = ~clk;

  eeprom_word_reader #(.PHASE_CLKS(PH)) u_eeprom_word_reader (
    .clk(clk), .rst_n(rst_n), .startReq(startReq), .startAddr(startAddr),
    .startCount(startCount), .busy(busy), .done(done), .errFlag(errFlag),
    .outValid(outValid), .outReady(outReady), .outByte(outByte),
    .romCs(romCs), .romSk(romSk), .romDi(romDi), .romDo(romDo)
  );

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // memory content: word w holds {2'b10, w} in bits 15:8 and {2'b01, ~w} in bits 7:0
  function automatic logic [7:0] expByte(input logic [6:0] byteAddr, input int k);
    logic [5:0] w;
    w = byteAddr[6:1] + 6'(k / 2);
    return (k % 2 == 0) ? {2'b01, ~w} : {2'b10, w};
  endfunction

  // responder for the serial memory
  int         rc = 0;
  int         protoErr = 0;
  logic [2:0] cmdSeen = '0;
  logic [5:0] addrSeen = '0;
  logic [15:0] wordOut = '0;

  always @(posedge romSk or negedge romCs) begin
    if (romCs === 1'b1) begin
      rc++;
      if (rc == 1) begin
        if (romDi !== 1'b0) protoErr++;
      end else if (rc <= 4) begin
        cmdSeen = {cmdSeen[1:0], romDi};
      end else if (rc <= 10) begin
        addrSeen = {addrSeen[4:0], romDi};
        if (rc == 10) begin
          if (cmdSeen != 3'b110) protoErr++;
          wordOut = {2'b10, addrSeen, 2'b01, ~addrSeen};
        end
      end else if (rc <= 26) begin
        romDo = wordOut[26 - rc];
      end else begin
        protoErr++;
      end
    end else if (romSk === 1'b1) begin
      protoErr++;
    end else begin
      if (rc != 0 && rc != 26) protoErr++;
      rc = 0;
    end
  end

  // consumer and pin monitors
  int         readyMode = 0;
  int         stallCtr = 0;
  int         gotCnt = 0;
  logic [7:0] gotBytes [0:63];
  int         csOverlap = 0;
  int         csActive = 0;
  int         skRun = 0;
  int         skMinHigh = 1000;

  always @(negedge clk) begin
    stallCtr++;
    case (readyMode)
      0:       outReady = 1'b1;
      1:       outReady = (stallCtr % 4 == 3);
      default: outReady = 1'b0;
    endcase
    if (outValid && outReady) begin
      if (gotCnt < 64) gotBytes[gotCnt] = outByte;
      gotCnt++;
    end
    if (outValid && romCs) csOverlap++;
    if (romCs) csActive++;
    if (romSk) skRun++;
    else begin
      if (skRun > 0 && skRun < skMinHigh) skMinHigh = skRun;
      skRun = 0;
    end
  end

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic startXfer(input logic [6:0] a, input logic [7:0] c);
    @(negedge clk);
    startAddr = a;
    startCount = c;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
  endtask

  task automatic waitDone();
    while (!done) @(negedge clk);
  endtask

  task automatic checkBytes(input logic [6:0] a, input int c, input string req);
    int bad = -1;
    check(gotCnt == c, req, gotCnt, c);
    for (int k = 0; k < c && k < 64; k++) begin
      if (bad < 0 && gotBytes[k] !== expByte(a, k)) bad = k;
    end
    if (bad < 0) check(1'b1, req, 0, 0);
    else check(1'b0, req, gotBytes[bad], expByte(a, bad));
  endtask

  // address(7) count(8) stalling consumer(1)
  localparam logic [15:0] VECS [4] = '{
    {7'd0,   8'd2, 1'b0},
    {7'd126, 8'd4, 1'b0},   // wraps from word 63 to word 0
    {7'd20,  8'd6, 1'b1},
    {7'd66,  8'd8, 1'b1}
  };

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(!busy && !done && !errFlag && !outValid && !romCs && !romSk && !romDi,
          "R10 reset state", {busy, done, errFlag, outValid, romCs, romSk, romDi}, 0);

    // R4/R5/R7 table of transfers
    for (int v = 0; v < 4; v++) begin
      readyMode = int'(VECS[v][0]);
      gotCnt = 0;
      startXfer(VECS[v][15:9], VECS[v][8:1]);
      waitDone();
      checkBytes(VECS[v][15:9], int'(VECS[v][8:1]), "R4/R5/R7 vector bytes");
    end
    readyMode = 0;

    // R1 malformed requests
    for (int b = 0; b < 3; b++) begin
      int act0;
      act0 = csActive;
      startXfer((b == 0) ? 7'd3 : 7'd4, (b == 1) ? 8'd0 : ((b == 2) ? 8'd3 : 8'd2));
      check(errFlag === 1'b1, "R1 error pulse", errFlag, 1);
      repeat (30) @(negedge clk);
      check(csActive == act0 && !busy && !errFlag, "R1 no bus activity", csActive - act0, 0);
    end

    // R8 consumer stall
    readyMode = 2;
    gotCnt = 0;
    startXfer(7'd10, 8'd2);
    while (!outValid) @(negedge clk);
    begin
      logic [7:0] held;
      held = outByte;
      repeat (12) @(negedge clk);
      check(outValid && outByte == held && !romCs && !romSk, "R8 stall holds byte",
            outByte, held);
    end
    readyMode = 0;
    waitDone();
    checkBytes(7'd10, 2, "R8 bytes after stall");

    // R10 start while busy is ignored
    gotCnt = 0;
    startXfer(7'd8, 8'd4);
    repeat (50) @(negedge clk);
    check(busy, "R10 busy during transfer", busy, 1);
    startAddr = 7'd40;
    startCount = 8'd2;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    waitDone();
    checkBytes(7'd8, 4, "R10 ignored mid-transfer start");
    @(negedge clk);
    check(!done && !busy, "R10 done single cycle", done, 0);

    // R11 start in the done cycle
    gotCnt = 0;
    startXfer(7'd12, 8'd2);
    waitDone();
    checkBytes(7'd12, 2, "R11 first transfer");
    gotCnt = 0;
    startAddr = 7'd30;
    startCount = 8'd2;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    check(busy, "R11 accepted alongside done", busy, 1);
    waitDone();
    checkBytes(7'd30, 2, "R11 second transfer");

    repeat (5) @(negedge clk);
    check(protoErr == 0, "R2/R3 serial framing", protoErr, 0);
    check(csOverlap == 0, "R6 cs low while output valid", csOverlap, 0);
    check(skMinHigh >= PH, "R9 clock high length", skMinHigh, PH);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule